// File: doc/BRIEF.md
# Tile background renderer

This block turns one row of a tile map into a stream of 8-bit colour pixels for the background layer of a small retro video system. A line is started with a one-cycle pulse carrying the line number. The block then walks the visible width tile by tile. For each tile it reads a 16-bit map entry. The entry holds a 6-bit palette selector and a 10-bit tile index. The block then reads the 16-bit row of that 2-bit-per-pixel, 8x8-pixel tile for the current line.

Each 2-bit pixel is combined with the entry's selector to form an address into a palette memory. Every selector therefore picks all four colours of its tile on its own. The colour byte that comes back is RRGGBBII: red in bits 7:6, green in 5:4, blue in 3:2, and two low-order intensity bits in 1:0 shared by all channels. The block passes that byte to the output unchanged, and holds each pixel for a fixed number of clocks.

The map entry and tile row for the next tile are fetched while the current tile is still being shown, so a line never stalls once it has begun. All three memories sit outside the block behind simple synchronous read ports. The output stream has a valid flag but no ready input. The consumer, a video DAC, cannot apply back-pressure and must take every pixel in the cycles it is held.

Top module: `tile_bg_renderer`

## Requirements
- R1: While reset is asserted and after it is released, `pix_vld` is 0 and `pix_col` is 8'h00 until a line is started.
- R2: When `line_start` is high at a clock edge while the block is idle and `line_y` < VIS_H, pixel 0 appears 6 edges later. After that, VIS_W pixels follow back to back, and `pix_vld` falls CPP*VIS_W edges after pixel 0 first appeared.
- R3: Each pixel is held on `pix_col` with `pix_vld` high for exactly CPP clock cycles, with no gap across tile boundaries.
- R4: The map entry for pixel x on line y is read at address (y/8)*MAP_W + x/8. In that entry, bits 15:10 are the palette selector and bits 9:0 are the tile index.
- R5: The tile row is read at address {tile index, y mod 8}. Pixel x mod 8 = j takes row bits [15-2j : 14-2j], so the leftmost pixel is in bits 15:14.
- R6: The palette is read at address {selector, pixel value}, 8 bits wide, and the returned byte is output on `pix_col` unchanged. All three read ports return data on the edge after the address is presented.
- R7: Outside the visible span of a line (before pixel 0 and after the last pixel), `pix_col` is 8'h00 and `pix_vld` is 0.
- R8: A `line_start` with `line_y` >= VIS_H is ignored: no pixel is produced.
- R9: A `line_start` that arrives while a line is in progress, including its final drain cycles, is ignored, and the line in progress completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle pulse that starts a line |
| line_y | input | LINE_W | Line number sampled with `line_start` |
| map_addr | output | MA_W | Tile map read address |
| map_rdata | input | 16 | Map entry, one cycle after the address |
| tile_addr | output | TILE_IDX_W+3 | Tile row read address {index, row} |
| tile_rdata | input | 16 | Tile row, one cycle after the address |
| pal_addr | output | PAL_SEL_W+2 | Palette read address {selector, pixel} |
| pal_rdata | input | 8 | RRGGBBII colour, one cycle after the address |
| pix_col | output | 8 | Output colour byte |
| pix_vld | output | 1 | High while `pix_col` carries a visible pixel |

## Verification
Each result has a fixed due cycle, counted in clock edges after the edge that samples `line_start`. Pixel k is due 6 + CPP*k edges later and stays until the next pixel replaces it. The valid flag drops 6 + CPP*VIS_W edges after the start. The bench counts edges from the start pulse and compares both outputs at the falling edge of every cycle against a value computed from those edge counts and from arithmetic models of the three memories. Retrigger pulses are timed to land inside a line and on its very last drain edge, and the following cycles are checked against the original line only.

// File: rtl/tbg_pkg.sv
package tbg_pkg;
  localparam int TILE_PX = 8;
  localparam int ROW_W   = 2 * TILE_PX;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRO,
    ST_RUN,
    ST_DRAIN
  } tbg_state_e;
endpackage

// File: rtl/tbg_seq.sv
module tbg_seq
  import tbg_pkg::*;
#(
  parameter int VIS_W  = 288,
  parameter int VIS_H  = 216,
  parameter int CPP    = 7,
  parameter int LINE_W = 8,
  localparam int PX_W  = $clog2(VIS_W),
  localparam int PH_W  = $clog2(CPP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [LINE_W-1:0] line_y,
  output tbg_state_e        state,
  output logic [PH_W-1:0]   ph,
  output logic [PX_W-1:0]   px,
  output logic [LINE_W-1:0] yl
);
  logic busy;
  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ph    <= '0;
      px    <= '0;
      yl    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (line_start && int'(line_y) < VIS_H) begin
            state <= ST_PRO;
            ph    <= '0;
            px    <= '0;
            yl    <= line_y;
          end
        end
        ST_PRO: begin
          if (ph == PH_W'(3)) begin
            state <= ST_RUN;
            ph    <= '0;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        ST_RUN: begin
          if (ph == PH_W'(CPP - 1)) begin
            ph <= '0;
            if (px == PX_W'(VIS_W - 1)) begin
              state <= ST_DRAIN;
              px    <= '0;
            end else begin
              px <= px + 1'b1;
            end
          end else begin
            ph <= ph + 1'b1;
          end
        end
        default: begin
          if (ph == PH_W'(1)) begin
            state <= ST_IDLE;
            ph    <= '0;
          end else begin
            ph <= ph + 1'b1;
          end
        end
      endcase
    end
  end

  // R9: a start pulse during an active line leaves the latched line unchanged
  a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && line_start) |=> $stable(yl));

  // R8: an off-screen line number never leaves the idle state
  a_r8_offscreen: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && line_start && int'(line_y) >= VIS_H) |=> (state == ST_IDLE));

  // R3: the phase counter stays inside one pixel period
  a_r3_ph_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ph) < CPP);
endmodule

// File: rtl/tbg_fetch.sv
module tbg_fetch
  import tbg_pkg::*;
#(
  parameter int VIS_W      = 288,
  parameter int MAP_W      = 36,
  parameter int CPP        = 7,
  parameter int LINE_W     = 8,
  parameter int MA_W       = 11,
  parameter int PAL_SEL_W  = 6,
  parameter int TILE_IDX_W = 10,
  localparam int PX_W      = $clog2(VIS_W),
  localparam int PH_W      = $clog2(CPP),
  localparam int NT        = VIS_W / TILE_PX,
  localparam int ENT_W     = PAL_SEL_W + TILE_IDX_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  tbg_state_e              state,
  input  logic [PH_W-1:0]         ph,
  input  logic [PX_W-1:0]         px,
  input  logic [LINE_W-1:0]       yl,
  input  logic [ENT_W-1:0]        map_rdata,
  input  logic [ROW_W-1:0]        tile_rdata,
  output logic [MA_W-1:0]         map_addr,
  output logic [TILE_IDX_W+2:0]   tile_addr,
  output logic [PAL_SEL_W-1:0]    cur_sel,
  output logic [ROW_W-1:0]        cur_row
);
  logic [PAL_SEL_W-1:0] nxt_sel;
  logic [ROW_W-1:0]     nxt_row;
  logic                 fetch_on;
  logic                 xfer;
  int                   tile_i;
  int                   fidx;

  always_comb begin
    tile_i   = int'(px) >> 3;
    fetch_on = (state == ST_PRO) ||
               (state == ST_RUN && px[2:0] == 3'd0 && tile_i + 1 < NT);
    fidx     = (state == ST_PRO) ? 0 : tile_i + 1;
    map_addr = MA_W'((int'(yl) >> 3) * MAP_W + fidx);
    xfer     = (state == ST_PRO && ph == PH_W'(3)) ||
               (state == ST_RUN && px[2:0] == 3'd7 && ph == PH_W'(CPP - 1));
  end

  assign tile_addr = {map_rdata[TILE_IDX_W-1:0], yl[2:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nxt_sel <= '0;
      nxt_row <= '0;
      cur_sel <= '0;
      cur_row <= '0;
    end else begin
      if (fetch_on && ph == PH_W'(1)) nxt_sel <= map_rdata[ENT_W-1:TILE_IDX_W];
      if (fetch_on && ph == PH_W'(2)) nxt_row <= tile_rdata;
      if (xfer) begin
        cur_sel <= nxt_sel;
        cur_row <= nxt_row;
      end
    end
  end

  // R5: the displayed tile row only changes at the end of a tile
  a_r5_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && px[2:0] != 3'd7) |=> $stable(cur_row));

  // R4: the palette selector only changes at the end of a tile
  a_r4_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && px[2:0] != 3'd7) |=> $stable(cur_sel));
endmodule

// File: rtl/tbg_pixel.sv
module tbg_pixel
  import tbg_pkg::*;
#(
  parameter int CPP       = 7,
  parameter int PAL_SEL_W = 6,
  localparam int PH_W     = $clog2(CPP)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  tbg_state_e             state,
  input  logic [PH_W-1:0]        ph,
  input  logic [2:0]             sub,
  input  logic [PAL_SEL_W-1:0]   cur_sel,
  input  logic [ROW_W-1:0]       cur_row,
  input  logic [7:0]             pal_rdata,
  output logic [PAL_SEL_W+1:0]   pal_addr,
  output logic [7:0]             out_col,
  output logic                   out_vld
);
  logic [1:0] fld [TILE_PX];

  for (genvar j = 0; j < TILE_PX; j++) begin : g_fld
    assign fld[j] = cur_row[ROW_W-1-2*j -: 2];
  end

  assign pal_addr = {cur_sel, fld[sub]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_col <= '0;
      out_vld <= 1'b0;
    end else if (ph == PH_W'(1)) begin
      if (state == ST_RUN) begin
        out_col <= pal_rdata;
        out_vld <= 1'b1;
      end else if (state == ST_DRAIN) begin
        out_col <= '0;
        out_vld <= 1'b0;
      end
    end
  end

  // R3: the output byte is held between pixel load points
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PH_W'(1)) |=> $stable(out_col));

  // R7: a blanked output carries zero
  a_r7_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> (out_col == 8'h00));

  // R7: nothing is valid while idle or in the line prologue
  a_r7_idle_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_PRO) |-> !out_vld);
endmodule

// File: rtl/tile_bg_renderer.sv
module tile_bg_renderer
  import tbg_pkg::*;
#(
  parameter int VIS_W      = 288,
  parameter int VIS_H      = 216,
  parameter int MAP_W      = 36,
  parameter int CPP        = 7,
  parameter int LINE_W     = 8,
  parameter int PAL_SEL_W  = 6,
  parameter int TILE_IDX_W = 10,
  localparam int MAP_ROWS  = (VIS_H + TILE_PX - 1) / TILE_PX,
  localparam int MA_W      = $clog2(MAP_W * MAP_ROWS),
  localparam int PX_W      = $clog2(VIS_W),
  localparam int PH_W      = $clog2(CPP),
  localparam int ENT_W     = PAL_SEL_W + TILE_IDX_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    line_start,
  input  logic [LINE_W-1:0]       line_y,
  output logic [MA_W-1:0]         map_addr,
  input  logic [ENT_W-1:0]        map_rdata,
  output logic [TILE_IDX_W+2:0]   tile_addr,
  input  logic [ROW_W-1:0]        tile_rdata,
  output logic [PAL_SEL_W+1:0]    pal_addr,
  input  logic [7:0]              pal_rdata,
  output logic [7:0]              pix_col,
  output logic                    pix_vld
);
  tbg_state_e           state;
  logic [PH_W-1:0]      ph;
  logic [PX_W-1:0]      px;
  logic [LINE_W-1:0]    yl;
  logic [PAL_SEL_W-1:0] cur_sel;
  logic [ROW_W-1:0]     cur_row;

  tbg_seq #(
    .VIS_W(VIS_W), .VIS_H(VIS_H), .CPP(CPP), .LINE_W(LINE_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_y(line_y),
    .state(state), .ph(ph), .px(px), .yl(yl)
  );

  tbg_fetch #(
    .VIS_W(VIS_W), .MAP_W(MAP_W), .CPP(CPP), .LINE_W(LINE_W), .MA_W(MA_W),
    .PAL_SEL_W(PAL_SEL_W), .TILE_IDX_W(TILE_IDX_W)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .state(state), .ph(ph), .px(px), .yl(yl),
    .map_rdata(map_rdata), .tile_rdata(tile_rdata), .map_addr(map_addr),
    .tile_addr(tile_addr), .cur_sel(cur_sel), .cur_row(cur_row)
  );

  tbg_pixel #(
    .CPP(CPP), .PAL_SEL_W(PAL_SEL_W)
  ) u_pixel (
    .clk(clk), .rst_n(rst_n), .state(state), .ph(ph), .sub(px[2:0]),
    .cur_sel(cur_sel), .cur_row(cur_row), .pal_rdata(pal_rdata),
    .pal_addr(pal_addr), .out_col(pix_col), .out_vld(pix_vld)
  );

  // R2: valid only rises when the first pixel of a line is loaded
  a_r2_rise_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_vld) |-> (state == ST_RUN && px == '0 && ph == PH_W'(2)));
endmodule

// File: tb/tb_tile_bg_renderer.sv
module tb_tile_bg_renderer;
  localparam int VIS_W = 32;
  localparam int VIS_H = 24;
  localparam int MAP_W = 6;
  localparam int CPP   = 7;
  localparam int MA_W  = $clog2(MAP_W * ((VIS_H + 7) / 8));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_start = 1'b0;
  logic [7:0] line_y = '0;
  logic [MA_W-1:0] map_addr;
  logic [15:0] map_rdata = '0;
  logic [12:0] tile_addr;
  logic [15:0] tile_rdata = '0;
  logic [7:0] pal_addr;
  logic [7:0] pal_rdata = '0;
  logic [7:0] pix_col;
  logic pix_vld;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  tile_bg_renderer #(
    .VIS_W(VIS_W), .VIS_H(VIS_H), .MAP_W(MAP_W), .CPP(CPP)
  ) dut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_y(line_y),
    .map_addr(map_addr), .map_rdata(map_rdata), .tile_addr(tile_addr),
    .tile_rdata(tile_rdata), .pal_addr(pal_addr), .pal_rdata(pal_rdata),
    .pix_col(pix_col), .pix_vld(pix_vld)
  );

  function automatic logic [15:0] map_f(int a);
    return 16'((((a * 7 + 3) & 63) << 10) | ((a * 37 + 5) & 1023));
  endfunction
  function automatic logic [15:0] tile_f(int a);
    return 16'((a * 40503) ^ 23100);
  endfunction
  function automatic logic [7:0] pal_f(int a);
    return 8'(a * 29 + 11);
  endfunction

  // memory models: one-cycle synchronous reads (R6)
  always @(posedge clk) begin
    map_rdata  <= map_f(int'(map_addr));
    tile_rdata <= tile_f(int'(tile_addr));
    pal_rdata  <= pal_f(int'(pal_addr));
  end

  // R4 map address, R5 row address and bit order, R6 palette address
  function automatic logic [7:0] exp_col(int y, int x);
    logic [15:0] e;
    logic [15:0] r;
    int sel, idx, pix;
    e   = map_f((y / 8) * MAP_W + x / 8);
    sel = int'(e[15:10]);
    idx = int'(e[9:0]);
    r   = tile_f(idx * 8 + y % 8);
    pix = int'((r >> (14 - 2 * (x % 8))) & 16'd3);
    return pal_f(sel * 4 + pix);
  endfunction

  task automatic chk(string tag, logic ev, logic [7:0] ec);
    tests++;
    if (pix_vld !== ev || pix_col !== ec) begin
      fails++;
      $display("FAIL %s: got vld=%0b col=%02h, expected vld=%0b col=%02h",
               tag, pix_vld, pix_col, ev, ec);
    end
  endtask

  // start line y; optionally pulse a retrigger so it is sampled at edge rc+1
  task automatic run_line(int y, int rc, int ry);
    int last;
    last = 7 * VIS_W + 9;
    @(negedge clk);
    line_y = 8'(y);
    line_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    line_start = 1'b0;
    for (int c = 1; c <= last; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (c >= 6 && c < 6 + CPP * VIS_W)
        chk(pix_vld ? "R6 pixel colour" : "R2 R3 pixel timing", 1'b1,
            exp_col(y, (c - 6) / CPP));
      else
        chk("R7 blank outside line", 1'b0, 8'h00);
      if (c == rc) begin
        line_start = 1'b1;
        line_y = 8'(ry);
      end else begin
        line_start = 1'b0;
        line_y = 8'(y);
      end
    end
  endtask

  task automatic idle_check(string tag, int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      chk(tag, 1'b0, 8'h00);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got no completion, expected end of run");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 during reset", 1'b0, 8'h00);
    rst_n = 1'b1;
    idle_check("R1 after reset", 5);

    // R2 R3 R4 R5 R6 R7: every visible line, every cycle
    // R9: even lines retrigger mid-line, odd lines on the final drain edge
    for (int y = 0; y < VIS_H; y++) begin
      if (y % 2 == 0) run_line(y, 50, (y + 5) % VIS_H);
      else            run_line(y, 5 + CPP * VIS_W, (y + 3) % VIS_H);
    end

    // R8: off-screen line numbers produce nothing
    @(negedge clk);
    line_y = 8'(VIS_H);
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    idle_check("R8 line VIS_H ignored", 40);
    line_y = 8'd255;
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    idle_check("R8 line 255 ignored", 40);

    // the block still starts normally afterwards
    run_line(VIS_H - 1, 0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule